// File: doc/BRIEF.md
# Display link lane count and rate selector

This block picks the lane count and the link rate for a display link from a video mode's pixel clock (in kHz), the pixel format, the sink's largest lane count and the sink's maximum-rate code, plus a flag for an external encoder that only runs at one fixed rate. A controller pulses `start`. The block copies all its inputs in that cycle, works through its candidates one after another, and then presents the chosen lanes and rate with a one-cycle `result_valid` strobe. The results stay on the outputs until the next run finishes.

Candidates are judged by a single capacity test. A mode fits a candidate when pixel clock × bits per pixel ≤ rate × lanes × 8. The lane search comes first and uses the sink's maximum rate. It starts at two lanes and doubles the count for as long as the count is below the sink's limit and the mode does not fit. The rate search then tries 162000 kHz, then 270000 kHz, and falls back to the sink's maximum.

The controller moves through the states ST_IDLE, ST_PREP, ST_LANE, ST_RATE_LO, ST_RATE_MID and ST_FINISH, with these transitions:
- ST_IDLE goes to ST_PREP when `start` is high.
- ST_PREP goes to ST_LANE. This state forms the bandwidth demand and decodes the sink rate.
- ST_LANE stays for MAXL_W-1 cycles, one lane candidate per cycle, and then goes to ST_RATE_LO.
- ST_RATE_LO goes to ST_RATE_MID.
- ST_RATE_MID goes to ST_FINISH.
- ST_FINISH registers the outputs, raises the strobe and returns to ST_IDLE.

Top module: `link_cfg_select`

## Requirements
- R1: After reset `busy`, `result_valid`, `fmt_err`, `lanes_out` and `rate_khz` are all 0.
- R2: `pix_fmt` codes map to bits per pixel as follows: 0 gives 8, 1 gives 16 (15-bit colour in a 16-bit word), 2 gives 16, 3 gives 24 (packed) and 4 gives 24 (a 32-bit word counted as 24 bits).
- R3: Codes 5 to 7 of `pix_fmt` are unsupported. They produce `lanes_out`=0, `rate_khz`=0 and `fmt_err`=1 in the strobe cycle. Any supported code gives `fmt_err`=0.
- R4: The sink rate code decodes as 8'h06 → 162000, 8'h0A → 270000 and 8'h14 → 540000 kHz. Any other code decodes to 162000 kHz.
- R5: The lane search begins at 2 and doubles while the count is below `sink_max_lanes` and the mode does not fit at the decoded sink rate. The result is never below 2, even when the sink limit is 0 or 1.
- R6: A mode fits exactly when pclk_khz × bpp ≤ rate × lanes × 8. Equality counts as a fit.
- R7: With `fixed_rate_enc`=0, the rate is 162000 when the mode fits at the chosen lanes. Otherwise it is 270000 when that fits. Otherwise it is the decoded sink maximum.
- R8: With `fixed_rate_enc`=1 the rate is 270000 kHz whatever the fit results. The lane search is unchanged.
- R9: `result_valid` is a one-cycle pulse. It rises on the (MAXL_W+3)-th rising edge after the edge that samples `start`. `lanes_out`, `rate_khz` and `fmt_err` change only at that edge.
- R10: While `busy` is high, `start` and every input change are ignored. The result belongs to the inputs sampled at the accepted start, and no extra run follows. `busy` falls only together with the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a selection when idle |
| pclk_khz | input | PCLK_W | Mode pixel clock in kHz |
| pix_fmt | input | 3 | Pixel format code (R2) |
| sink_max_lanes | input | MAXL_W | Sink's largest lane count |
| sink_rate_code | input | 8 | Sink maximum-rate code (R4) |
| fixed_rate_enc | input | 1 | External encoder fixed at 270000 kHz |
| busy | output | 1 | Selection in progress |
| result_valid | output | 1 | One-cycle strobe with a new result |
| lanes_out | output | MAXL_W+1 | Selected lane count |
| rate_khz | output | 20 | Selected link rate in kHz |
| fmt_err | output | 1 | Unsupported pixel format |

## Verification
On every cycle, the assertions check the following:
- the strobe is one cycle wide and comes at the fixed latency;
- `busy` ends only with the strobe;
- the outputs hold between strobes;
- an error result is all zeros;
- a valid lane count is a power of two of at least 2;
- a valid rate is one of the three decodable values, and it is 270000 when the fixed-rate flag was sampled.

The actual choice needs the bench's scenarios and its reference model. These include:
- which lane count and which rate a given pixel clock and format lead to;
- the exact equality boundary of the fit test;
- the decoding of unknown rate codes;
- the proof that a start pulse with altered inputs during a run leaves the result untouched.

// File: rtl/link_cfg_pkg.sv
package link_cfg_pkg;

    localparam int RATE_W = 20;
    localparam int BPP_W  = 5;
    localparam int FMT_W  = 3;
    localparam int CODE_W = 8;

    localparam logic [RATE_W-1:0] RATE_LOW_KHZ  = 20'd162000;
    localparam logic [RATE_W-1:0] RATE_MID_KHZ  = 20'd270000;
    localparam logic [RATE_W-1:0] RATE_HIGH_KHZ = 20'd540000;

    localparam logic [CODE_W-1:0] CODE_LOW  = 8'h06;
    localparam logic [CODE_W-1:0] CODE_MID  = 8'h0A;
    localparam logic [CODE_W-1:0] CODE_HIGH = 8'h14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_LANE,
        ST_RATE_LO,
        ST_RATE_MID,
        ST_FINISH
    } sel_state_t;

endpackage

// File: rtl/lcs_bpp_map.sv
module lcs_bpp_map
    import link_cfg_pkg::*;
(
    input  logic [FMT_W-1:0] fmt,
    output logic [BPP_W-1:0] bpp,
    output logic             supported
);
    always_comb begin
        supported = 1'b1;
        case (fmt)
            3'd0:    bpp = 5'd8;
            3'd1:    bpp = 5'd16;
            3'd2:    bpp = 5'd16;
            3'd3:    bpp = 5'd24;
            3'd4:    bpp = 5'd24;   // 32-bit storage, 24 bits carried
            default: begin
                bpp       = '0;
                supported = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lcs_rate_decode.sv
module lcs_rate_decode
    import link_cfg_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [RATE_W-1:0] rate
);
    always_comb begin
        case (code)
            CODE_MID:  rate = RATE_MID_KHZ;
            CODE_HIGH: rate = RATE_HIGH_KHZ;
            CODE_LOW:  rate = RATE_LOW_KHZ;
            default:   rate = RATE_LOW_KHZ;
        endcase
    end
endmodule

// File: rtl/lcs_fit_check.sv
module lcs_fit_check
    import link_cfg_pkg::*;
#(
    parameter int DEM_W = 25,
    parameter int LOG_W = 2,
    parameter int CMP_W = 26
) (
    input  logic [DEM_W-1:0]  demand,
    input  logic [RATE_W-1:0] cand_rate,
    input  logic [LOG_W-1:0]  cand_log,
    output logic              fits
);
    logic [LOG_W+1:0] shamt;
    logic [CMP_W-1:0] capacity;

    // capacity in bit-rate units: rate * 2^log * 8
    assign shamt    = (LOG_W+2)'(cand_log) + (LOG_W+2)'(3);
    assign capacity = CMP_W'(cand_rate) << shamt;
    assign fits     = CMP_W'(demand) <= capacity;
endmodule

// File: rtl/link_cfg_select.sv
module link_cfg_select
    import link_cfg_pkg::*;
#(
    parameter int PCLK_W = 20,
    parameter int MAXL_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [PCLK_W-1:0]   pclk_khz,
    input  logic [FMT_W-1:0]    pix_fmt,
    input  logic [MAXL_W-1:0]   sink_max_lanes,
    input  logic [CODE_W-1:0]   sink_rate_code,
    input  logic                fixed_rate_enc,
    output logic                busy,
    output logic                result_valid,
    output logic [MAXL_W:0]     lanes_out,
    output logic [RATE_W-1:0]   rate_khz,
    output logic                fmt_err
);
    localparam int LANE_W = MAXL_W + 1;
    localparam int LOG_W  = $clog2(MAXL_W + 1);
    localparam int NSTEP  = MAXL_W - 1;
    localparam int STEP_W = (NSTEP > 1) ? $clog2(NSTEP) : 1;
    localparam int DEM_W  = PCLK_W + BPP_W;
    localparam int CAP_W  = RATE_W + MAXL_W + 4;
    localparam int CMP_W  = (CAP_W > DEM_W) ? CAP_W : DEM_W;

    sel_state_t state_q, state_d;

    logic [PCLK_W-1:0] pclk_q;
    logic [FMT_W-1:0]  fmt_q;
    logic [MAXL_W-1:0] maxl_q;
    logic [CODE_W-1:0] code_q;
    logic              fixed_q;

    logic [DEM_W-1:0]  demand_q;
    logic [RATE_W-1:0] maxrate_q;
    logic              fmt_bad_q;
    logic [LOG_W-1:0]  lane_log_q;
    logic              frozen_q;
    logic [STEP_W-1:0] step_q;
    logic [RATE_W-1:0] rate_q;
    logic              rate_done_q;

    logic [BPP_W-1:0]  bpp_w;
    logic              fmt_ok_w;
    logic [RATE_W-1:0] dec_rate_w;
    logic [RATE_W-1:0] cand_rate_w;
    logic              fits_w;
    logic [LANE_W-1:0] lane_cur_w;
    logic [DEM_W-1:0]  demand_w;

    lcs_bpp_map u_bpp (
        .fmt       (fmt_q),
        .bpp       (bpp_w),
        .supported (fmt_ok_w)
    );

    lcs_rate_decode u_dec (
        .code (code_q),
        .rate (dec_rate_w)
    );

    lcs_fit_check #(
        .DEM_W (DEM_W),
        .LOG_W (LOG_W),
        .CMP_W (CMP_W)
    ) u_fit (
        .demand    (demand_q),
        .cand_rate (cand_rate_w),
        .cand_log  (lane_log_q),
        .fits      (fits_w)
    );

    assign lane_cur_w = LANE_W'(1) << lane_log_q;
    assign demand_w   = DEM_W'(pclk_q) * DEM_W'(bpp_w);
    assign busy       = (state_q != ST_IDLE);

    always_comb begin
        unique case (state_q)
            ST_LANE:    cand_rate_w = maxrate_q;
            ST_RATE_LO: cand_rate_w = RATE_LOW_KHZ;
            default:    cand_rate_w = RATE_MID_KHZ;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_PREP;
            ST_PREP:     state_d = ST_LANE;
            ST_LANE:     if (step_q == STEP_W'(NSTEP - 1)) state_d = ST_RATE_LO;
            ST_RATE_LO:  state_d = ST_RATE_MID;
            ST_RATE_MID: state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pclk_q       <= '0;
            fmt_q        <= '0;
            maxl_q       <= '0;
            code_q       <= '0;
            fixed_q      <= 1'b0;
            demand_q     <= '0;
            maxrate_q    <= '0;
            fmt_bad_q    <= 1'b0;
            lane_log_q   <= '0;
            frozen_q     <= 1'b0;
            step_q       <= '0;
            rate_q       <= '0;
            rate_done_q  <= 1'b0;
            result_valid <= 1'b0;
            lanes_out    <= '0;
            rate_khz     <= '0;
            fmt_err      <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pclk_q  <= pclk_khz;
                        fmt_q   <= pix_fmt;
                        maxl_q  <= sink_max_lanes;
                        code_q  <= sink_rate_code;
                        fixed_q <= fixed_rate_enc;
                    end
                end
                ST_PREP: begin
                    demand_q    <= demand_w;
                    maxrate_q   <= dec_rate_w;
                    fmt_bad_q   <= !fmt_ok_w;
                    lane_log_q  <= LOG_W'(1);
                    frozen_q    <= 1'b0;
                    step_q      <= '0;
                    rate_q      <= '0;
                    rate_done_q <= 1'b0;
                end
                ST_LANE: begin
                    step_q <= step_q + STEP_W'(1);
                    if (!frozen_q) begin
                        if (lane_cur_w < LANE_W'(maxl_q)) begin
                            if (fits_w) frozen_q <= 1'b1;
                            else        lane_log_q <= lane_log_q + LOG_W'(1);
                        end else begin
                            frozen_q <= 1'b1;
                        end
                    end
                end
                ST_RATE_LO: begin
                    if (fixed_q) begin
                        rate_q      <= RATE_MID_KHZ;
                        rate_done_q <= 1'b1;
                    end else if (fits_w) begin
                        rate_q      <= RATE_LOW_KHZ;
                        rate_done_q <= 1'b1;
                    end
                end
                ST_RATE_MID: begin
                    if (!rate_done_q) begin
                        rate_q      <= fits_w ? RATE_MID_KHZ : maxrate_q;
                        rate_done_q <= 1'b1;
                    end
                end
                ST_FINISH: begin
                    result_valid <= 1'b1;
                    if (fmt_bad_q) begin
                        lanes_out <= '0;
                        rate_khz  <= '0;
                        fmt_err   <= 1'b1;
                    end else begin
                        lanes_out <= lane_cur_w;
                        rate_khz  <= rate_q;
                        fmt_err   <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/link_cfg_select_chk.sv
module link_cfg_select_chk
    import link_cfg_pkg::*;
#(
    parameter int MAXL_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              result_valid,
    input logic [MAXL_W:0]   lanes_out,
    input logic [RATE_W-1:0] rate_khz,
    input logic              fmt_err,
    input logic              fixed_q
);
    localparam logic [7:0] LAT_MARK = 8'(MAXL_W + 4);

    logic [7:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cyc_q <= '0;
        else if (start && !busy)     cyc_q <= 8'd1;
        else if (result_valid)       cyc_q <= '0;
        else if (cyc_q != 8'd0)      cyc_q <= cyc_q + 8'd1;
    end

    // R9
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R9
    strobe_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> cyc_q == LAT_MARK);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> ($stable(lanes_out) && $stable(rate_khz) && $stable(fmt_err)));

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> result_valid);

    // R3
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && fmt_err) |-> (lanes_out == '0 && rate_khz == '0));

    // R5
    lane_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !fmt_err) |-> ($countones(lanes_out) == 1 && lanes_out >= 2));

    // R7
    rate_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !fmt_err) |-> (rate_khz == RATE_LOW_KHZ
            || rate_khz == RATE_MID_KHZ || rate_khz == RATE_HIGH_KHZ));

    // R8
    fixed_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !fmt_err && fixed_q) |-> rate_khz == RATE_MID_KHZ);
endmodule

bind link_cfg_select link_cfg_select_chk #(.MAXL_W(MAXL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .busy         (busy),
    .result_valid (result_valid),
    .lanes_out    (lanes_out),
    .rate_khz     (rate_khz),
    .fmt_err      (fmt_err),
    .fixed_q      (fixed_q)
);

// File: tb/link_cfg_select_test.sv
`timescale 1ns/1ps
module link_cfg_select_test;
    localparam int PCLK_W = 20;
    localparam int MAXL_W = 3;
    localparam int LAT    = MAXL_W + 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [PCLK_W-1:0] pclk_khz = '0;
    logic [2:0]        pix_fmt = '0;
    logic [MAXL_W-1:0] sink_max_lanes = '0;
    logic [7:0]        sink_rate_code = '0;
    logic              fixed_rate_enc = 1'b0;
    logic              busy;
    logic              result_valid;
    logic [MAXL_W:0]   lanes_out;
    logic [19:0]       rate_khz;
    logic              fmt_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    link_cfg_select #(.PCLK_W(PCLK_W), .MAXL_W(MAXL_W)) uut (
        .clk, .rst_n, .start, .pclk_khz, .pix_fmt, .sink_max_lanes,
        .sink_rate_code, .fixed_rate_enc, .busy, .result_valid,
        .lanes_out, .rate_khz, .fmt_err
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit fits(input int pix, input int bpp, input int rate, input int lanes);
        return longint'(pix) * bpp <= longint'(rate) * lanes * 8;
    endfunction

    task automatic model(input int pix, input int fmt, input int maxl, input int code,
                         input bit fx, output int el, output int er, output bit ee);
        int bpp;
        int mr;
        int lane;
        case (fmt)
            0: bpp = 8;
            1, 2: bpp = 16;
            3, 4: bpp = 24;
            default: bpp = 0;
        endcase
        if (bpp == 0) begin
            el = 0; er = 0; ee = 1;
            return;
        end
        ee = 0;
        mr = (code == 'h0A) ? 270000 : (code == 'h14) ? 540000 : 162000;
        lane = 2;
        while (lane < maxl) begin
            if (fits(pix, bpp, mr, lane)) break;
            lane = lane * 2;
        end
        el = lane;
        if (fx)                               er = 270000;
        else if (fits(pix, bpp, 162000, lane)) er = 162000;
        else if (fits(pix, bpp, 270000, lane)) er = 270000;
        else                                   er = mr;
    endtask

    task automatic run(input int pix, input int fmt, input int maxl, input int code,
                       input bit fx, input string tag, input bit disturb);
        int el, er, n;
        bit ee;
        model(pix, fmt, maxl, code, fx, el, er, ee);
        @(negedge clk);
        pclk_khz = PCLK_W'(pix);
        pix_fmt = 3'(fmt);
        sink_max_lanes = MAXL_W'(maxl);
        sink_rate_code = 8'(code);
        fixed_rate_enc = fx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (n < 40) begin
            @(posedge clk);
            #1;
            n++;
            if (result_valid) break;
            if (disturb && n == 1) begin
                start = 1'b1;
                pclk_khz = pclk_khz ^ 20'h5A5A5;
                pix_fmt = pix_fmt ^ 3'd6;
                sink_max_lanes = ~sink_max_lanes;
                sink_rate_code = 8'h14;
                fixed_rate_enc = ~fixed_rate_enc;
            end
            if (n == 3) start = 1'b0;
        end
        // R9 latency
        check(n == LAT && result_valid, "R9", "latency", n, LAT);
        check(lanes_out == (MAXL_W+1)'(el), ee ? "R3" : (disturb ? "R10" : "R5"),
              "lanes", lanes_out, el);
        check(rate_khz == 20'(er), ee ? "R3" : tag, "rate", rate_khz, er);
        check(fmt_err == ee, disturb ? "R10" : "R3", "fmt_err", fmt_err, ee);
        if (disturb) begin
            repeat (4) begin
                @(posedge clk);
                #1;
                // R10: no second run after an ignored start
                check(!result_valid && !busy, "R10", "extra run", result_valid, 0);
            end
            check(lanes_out == (MAXL_W+1)'(el), "R10", "lanes held", lanes_out, el);
        end
    endtask

    initial begin
        #200000;
        if (!finished) begin
            failures++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int codes[5];
        codes = '{'h06, 'h0A, 'h14, 'h00, 'h33};
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(!busy && !result_valid && !fmt_err, "R1", "flags", {busy, result_valid, fmt_err}, 0);
        check(lanes_out == 0 && rate_khz == 0, "R1", "data", rate_khz, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 format widths
        run(108000, 4, 4, 'h06, 0, "R2", 0);
        run(108000, 3, 4, 'h06, 0, "R2", 0);
        run(300000, 0, 4, 'h06, 0, "R2", 0);
        run(200000, 1, 4, 'h06, 0, "R2", 0);
        // R6 equality boundary and one above
        run(108001, 4, 4, 'h06, 0, "R6", 0);
        run(162000, 2, 2, 'h06, 0, "R6", 0);
        // R4 rate decode
        run(300000, 3, 4, 'h14, 0, "R4", 0);
        run(200000, 3, 4, 'h0A, 0, "R4", 0);
        run(200000, 3, 2, 'h55, 0, "R4", 0);
        // R5 lane floor
        run(500000, 3, 1, 'h06, 0, "R5", 0);
        run(500000, 3, 0, 'h14, 0, "R5", 0);
        run(600000, 3, 7, 'h06, 0, "R5", 0);
        // R7 order of rate candidates
        run(150000, 3, 2, 'h14, 0, "R7", 0);
        // R8 fixed-rate encoder
        run(10000, 3, 4, 'h14, 1, "R8", 0);
        run(600000, 0, 4, 'h06, 1, "R8", 0);
        // R3 unsupported formats
        run(100000, 5, 4, 'h06, 0, "R3", 0);
        run(100000, 7, 4, 'h14, 1, "R3", 0);
        // R10 start during busy
        run(250000, 3, 4, 'h0A, 0, "R10", 1);

        for (int i = 0; i < 60; i++) begin
            int pix, fmt, maxl, code;
            bit fx;
            pix  = int'($urandom % 700000);
            fmt  = int'($urandom % 8);
            maxl = int'($urandom % 8);
            code = codes[$urandom % 5];
            fx   = ($urandom % 6) == 0;
            run(pix, fmt, maxl, code, fx, fx ? "R8" : "R7", 0);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule